// File: doc/BRIEF.md
# Bitstream Sinc-4 Decimator by Four

This block turns a one-bit oversampled stream, as produced by a delta-sigma modulator, into multi-bit words at one quarter of the input rate. It applies a fourth-order sinc low-pass response, which is the cube of a four-tap moving sum convolved once more with itself, and keeps one result for every four input bits.

No integrators run at the input rate. A small front stage groups the incoming bits four at a time. Once a group is complete, the thirteen most recent bits are combined in one step. Each bit enables a constant weight, and a few narrow adders per group add these weights up, so no multiplier is used. The adders only need to settle once per output word. A later droop-correction or half-band stage would take the output words.

The widths follow from two parameters: the filter order and the decimation ratio. With the default values, order 4 and ratio 4, the output is nine bits wide and holds values up to 256.

Top module: `sinc4_bit_decimator`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its bit history, its group phase and both outputs. `out_vld` and `out_data` read 0 in the cycle after such an edge. Bits received before the reset never affect later outputs, and neither does a partly filled group.
- R2: Only edges where `in_vld` is high accept a bit; cycles with `in_vld` low are ignored. `out_vld` pulses high for one cycle once every four accepted bits, and never in two consecutive cycles.
- R3: Let x(0) be the fourth bit of the group just completed, x(-1) the bit before it, and so on back to x(-12). Each bit counts as 1 when high and 0 when low. The output is the sum of h(k)·x(-k) over k = 0..12 with h = 1,4,10,20,31,40,44,40,31,20,10,4,1.
- R4: Every bit before the first one accepted after reset counts as 0. As a result, the first three outputs after reset are at most 35, 190 and 255 in turn.
- R5: A constant stream of ones gives 256 from the fourth output onward. No output ever exceeds 256, and 256 fits in the 9-bit `out_data` without wrapping.
- R6: Two register stages lie between input and output. `out_vld` is high during the cycle that begins one rising edge after the edge that accepts the fourth bit of a group.
- R7: `out_data` changes only when a new result is presented with `out_vld` high. Between pulses it holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Strobe that marks `in_bit` as a new sample |
| in_bit | input | 1 | Bitstream sample, 1 counts as one and 0 as zero |
| out_vld | output | 1 | One-cycle strobe for a new output word |
| out_data | output | 9 | Unsigned filtered word, range 0..256 |

## Verification
A single one is placed at each of the four positions within a group. This makes every coefficient visible on its own, so a weight attached to the wrong bit or a bit order reversed inside a group shows up as a wrong value at once. A run of ones drives the output to 256, which exposes a result truncated to eight bits, since it would read 0. A reset issued halfway through a group, and stretches of idle strobe cycles, catch a phase counter that is not cleared or that counts idle cycles: that design would emit words at the wrong times or from the wrong bits. The first outputs after each reset are compared against a history that is all zeros, which shows whether stale bits survive the reset.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  // Impulse response of (1 + z^-1 + ... + z^-(ratio-1))^order, tap k.
  function automatic int sinc_coef(input int order, input int ratio, input int k);
    int cur [64];
    int nxt [64];
    int len;
    for (int i = 0; i < 64; i++) cur[i] = 0;
    cur[0] = 1;
    len = 1;
    for (int s = 0; s < order; s++) begin
      for (int i = 0; i < 64; i++) nxt[i] = 0;
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < ratio; j++)
          if (i - j >= 0 && i - j < len) nxt[i] += cur[i - j];
      len = len + ratio - 1;
      for (int i = 0; i < 64; i++) cur[i] = nxt[i];
    end
    if (k < 0 || k >= len || k >= 64) return 0;
    return cur[k];
  endfunction

  function automatic int sinc_taps(input int order, input int ratio);
    return order * (ratio - 1) + 1;
  endfunction

  function automatic int sinc_groups(input int order, input int ratio);
    return (sinc_taps(order, ratio) + ratio - 1) / ratio;
  endfunction

  // Largest partial sum of group g (all its bits high).
  function automatic int group_max(input int order, input int ratio, input int g);
    int acc;
    acc = 0;
    for (int j = 0; j < ratio; j++) acc += sinc_coef(order, ratio, g * ratio + j);
    return acc;
  endfunction

  // Largest output when only groups 0..upto may hold ones.
  function automatic int cum_bound(input int order, input int ratio, input int upto);
    int acc;
    acc = 0;
    for (int g = 0; g <= upto; g++) acc += group_max(order, ratio, g);
    return acc;
  endfunction

endpackage

// File: rtl/sdec_bit_gather.sv
module sdec_bit_gather #(
  parameter int RATIO = 4,
  localparam int PH_W = (RATIO > 2) ? $clog2(RATIO) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_bit,
  output logic             grp_vld,
  output logic [RATIO-1:0] grp_bits
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(RATIO - 1);

  logic [PH_W-1:0]  ph_q;
  logic [RATIO-1:0] sh_q;
  logic [RATIO-1:0] sh_nxt;

  // bit 0 is always the newest sample
  assign sh_nxt = {sh_q[RATIO-2:0], in_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= '0;
      sh_q     <= '0;
      grp_vld  <= 1'b0;
      grp_bits <= '0;
    end else begin
      grp_vld <= 1'b0;
      if (in_vld) begin
        sh_q <= sh_nxt;
        if (ph_q == LAST_PH) begin
          ph_q     <= '0;
          grp_vld  <= 1'b1;
          grp_bits <= sh_nxt;
        end else begin
          ph_q <= ph_q + PH_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sdec_group_hist.sv
module sdec_group_hist #(
  parameter int RATIO = 4,
  parameter int NHIST = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       shift_en,
  input  logic [RATIO-1:0]           new_grp,
  output logic [NHIST-1:0][RATIO-1:0] hist
);

  genvar s;
  generate
    for (s = 0; s < NHIST; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          hist[s] <= '0;
        end else if (shift_en) begin
          if (s == 0) hist[s] <= new_grp;
          else        hist[s] <= hist[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sdec_group_wsum.sv
module sdec_group_wsum
  import sdec_pkg::*;
#(
  parameter int ORDER = 4,
  parameter int RATIO = 4,
  parameter int GIDX  = 0,
  parameter int SUM_W = 9
) (
  input  logic [RATIO-1:0] bits,
  output logic [SUM_W-1:0] psum
);

  localparam int GMAX = group_max(ORDER, RATIO, GIDX);
  localparam int LW   = (GMAX < 2) ? 1 : $clog2(GMAX + 1);

  logic [RATIO-1:0][LW-1:0] term;
  logic [LW-1:0]            acc;

  // each bit gates a constant weight; narrow adder per group
  genvar j;
  generate
    for (j = 0; j < RATIO; j++) begin : g_tap
      localparam int WJ = sinc_coef(ORDER, RATIO, GIDX * RATIO + j);
      assign term[j] = bits[j] ? LW'(WJ) : '0;
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < RATIO; k++) acc = acc + term[k];
  end

  assign psum = SUM_W'(acc);

endmodule

// File: rtl/sinc4_bit_decimator.sv
module sinc4_bit_decimator
  import sdec_pkg::*;
#(
  parameter int ORDER = 4,
  parameter int RATIO = 4,
  localparam int OUT_W = 1 + ORDER * $clog2(RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_bit,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_data
);

  localparam int NGRP  = sinc_groups(ORDER, RATIO);
  localparam int NHIST = (NGRP > 1) ? NGRP - 1 : 1;

  logic                        grp_vld;
  logic [RATIO-1:0]            grp_bits;
  logic [NHIST-1:0][RATIO-1:0] hist;
  logic [NGRP-1:0][OUT_W-1:0]  psum;
  logic [OUT_W-1:0]            total;

  sdec_bit_gather #(.RATIO(RATIO)) gather_i (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_bit   (in_bit),
    .grp_vld  (grp_vld),
    .grp_bits (grp_bits)
  );

  sdec_group_hist #(.RATIO(RATIO), .NHIST(NHIST)) hist_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (grp_vld),
    .new_grp  (grp_bits),
    .hist     (hist)
  );

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      logic [RATIO-1:0] gb;
      if (g == 0) begin : g_new
        assign gb = grp_bits;
      end else begin : g_old
        assign gb = hist[g - 1];
      end
      sdec_group_wsum #(
        .ORDER (ORDER),
        .RATIO (RATIO),
        .GIDX  (g),
        .SUM_W (OUT_W)
      ) wsum_i (
        .bits (gb),
        .psum (psum[g])
      );
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int k = 0; k < NGRP; k++) total = total + psum[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= grp_vld;
      if (grp_vld) out_data <= total;
    end
  end

endmodule

// File: rtl/sinc4_bit_decimator_chk.sv
module sinc4_bit_decimator_chk
  import sdec_pkg::*;
#(
  parameter int ORDER = 4,
  parameter int RATIO = 4,
  parameter int OUT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             out_vld,
  input logic [OUT_W-1:0] out_data
);

  localparam int PH_W  = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam int NGRP  = sinc_groups(ORDER, RATIO);
  localparam int CNT_W = $clog2(NGRP) + 1;
  localparam int MAXV  = RATIO ** ORDER;

  logic [PH_W-1:0]  ph_q;
  logic             acc_q;
  logic [CNT_W-1:0] ocnt_q;
  int               lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      acc_q  <= 1'b0;
      ocnt_q <= '0;
    end else begin
      acc_q <= in_vld && (ph_q == PH_W'(RATIO - 1));
      if (in_vld) ph_q <= (ph_q == PH_W'(RATIO - 1)) ? '0 : ph_q + PH_W'(1);
      if (out_vld && ocnt_q < CNT_W'(NGRP - 1)) ocnt_q <= ocnt_q + CNT_W'(1);
    end
  end

  always_comb lim = cum_bound(ORDER, RATIO, int'(ocnt_q));

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && out_data == '0));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  // R4
  partial_hist_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && ocnt_q < CNT_W'(NGRP - 1)) |-> (int'(out_data) <= lim));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (int'(out_data) <= MAXV));

  // R6
  latency_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q |=> out_vld);

  // R6
  latency_back_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(acc_q));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> $stable(out_data));

endmodule

bind sinc4_bit_decimator sinc4_bit_decimator_chk #(
  .ORDER (ORDER),
  .RATIO (RATIO),
  .OUT_W (OUT_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .out_vld  (out_vld),
  .out_data (out_data)
);

// File: tb/sinc4_bit_decimator_tb_top.sv
`timescale 1ns/1ps
module sinc4_bit_decimator_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_vld;
  logic [8:0] out_data;

  sinc4_bit_decimator dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_bit   (in_bit),
    .out_vld  (out_vld),
    .out_data (out_data)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_chk = 0;
  int    n_err = 0;
  int    coef [13] = '{1, 4, 10, 20, 31, 40, 44, 40, 31, 20, 10, 4, 1};
  int    mh [13];
  int    mph = 0;
  int    out_idx = 0;
  int    pushed = 0;
  int    seen = 0;
  int    last_data = 0;
  string phase_tag = "R3";
  bit    done = 1'b0;

  int    exp_q [$];
  int    cyc_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 13; k++) mh[k] = 0;
    mph     = 0;
    out_idx = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst    = 1'b1;
    in_vld = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is applied
    check(out_vld == 1'b0, "R1 out_vld in reset", int'(out_vld), 0);
    check(out_data == 9'd0, "R1 out_data in reset", int'(out_data), 0);
    model_clear();
    rst = 1'b0;
  endtask

  task automatic send(input bit b, input int gap);
    int e;
    repeat (gap) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
    @(negedge clk);
    in_vld = 1'b1;
    in_bit = b;
    for (int k = 12; k > 0; k--) mh[k] = mh[k-1];
    mh[0] = int'(b);
    mph++;
    if (mph == 4) begin
      mph = 0;
      e = 0;
      for (int k = 0; k < 13; k++) e += coef[k] * mh[k];
      exp_q.push_back(e);
      cyc_q.push_back(cyc + 2);
      tag_q.push_back(out_idx < 3 ? {phase_tag, "/R4"} : phase_tag);
      out_idx++;
      pushed++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      last_data = 0;
    end else if (out_vld) begin
      seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_vld", int'(out_data), -1);
      end else begin
        int    e;
        int    c;
        string t;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        t = tag_q.pop_front();
        check(int'(out_data) == e, t, int'(out_data), e);
        check(cyc == c, "R6 output cycle", cyc, c);
      end
      last_data = int'(out_data);
    end else begin
      check(int'(out_data) == last_data, "R7 hold between pulses", int'(out_data), last_data);
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();

    // R3: single one at each position within a group, zero history
    for (int p = 0; p < 4; p++) begin
      phase_tag = "R3 impulse";
      for (int z = 0; z < p; z++) send(1'b0, 0);
      send(1'b1, 0);
      for (int z = 0; z < 19 - p; z++) send(1'b0, 0);
      idle(6);
      do_reset();
    end

    // R1: reset in the middle of a group clears phase and history
    phase_tag = "R1 mid-group reset";
    send(1'b1, 0);
    send(1'b1, 0);
    idle(2);
    do_reset();
    for (int z = 0; z < 8; z++) send(1'b1, 0);
    idle(6);
    do_reset();

    // R5: steady stream of ones
    phase_tag = "R5 all ones";
    for (int z = 0; z < 48; z++) send(1'b1, 0);
    idle(6);

    // R3: random bits, back to back
    do_reset();
    phase_tag = "R3 random";
    for (int z = 0; z < 400; z++) send(1'($urandom_range(0, 1)), 0);
    idle(6);

    // R2: random bits with idle gaps on the strobe
    phase_tag = "R2 gapped random";
    for (int z = 0; z < 240; z++) send(1'($urandom_range(0, 1)), $urandom_range(0, 3));
    idle(8);

    // R2: one pulse per four accepted bits, nothing left over
    check(seen == pushed, "R2 output count", seen, pushed);
    check(exp_q.size() == 0, "R2 pending results", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule